// File: doc/BRIEF.md
# Clock-Compensating Receive Elastic Buffer

This block sits on one receive channel, just after character decoding. It carries decoded characters from the recovered clock of that channel into the local reference clock domain. The two clocks may run at slightly different frequencies, or at the same frequency with an unknown phase. Each stored entry is an 11-bit word made of an 8-bit character and a 3-bit status code.

The block does not report overflow like a plain FIFO. It holds its fill level near the middle by adjusting the stream, and it only touches framing characters. A framing character is data 0xBC with status 3'b001. When the read side sees a framing character at the head while the buffer runs full, it discards that character. When it sees one while the buffer runs low, it emits the character and keeps it at the head, so the character is repeated. The stream must carry framing characters often enough for this to keep up. If the fill level still hits a hard limit, a sticky error flag is raised and the read pointer jumps back to its nominal distance behind the write pointer.

When the read side is clocked by the recovered clock itself, a bypass input routes the incoming character straight into the output register, and nothing is added or removed.

Top module: `elastic_rx_buf`

## Requirements
- R1: While either reset is high, and on the first read cycle after reset, the output is 0xBC with status 3'b001 and both error flags are low. The buffer starts 5 entries full of that character, with the write pointer 5 entries ahead of the read pointer.
- R2: With no error and bypass low, every non-framing character written comes out in write order, once, with data and status unchanged.
- R3: When the head entry is a framing character (data 0xBC, status 3'b001) and the read-side occupancy is 5 or more (below the overflow limit), that entry is discarded. The entry after it is output, and the read pointer advances by two.
- R4: When the head entry is a framing character and the read-side occupancy is 2 or less (but not zero), that character is output and the read pointer does not move. This inserts one extra 0xBC / 3'b001.
- R5: Only framing characters are ever added or removed. Any character the block adds is exactly data 0xBC with status 3'b001.
- R6: When the read-side occupancy reaches 8 or more, the overflow flag is set, 0xBC / 3'b001 is output, and the read pointer is set 5 entries behind the synchronised write pointer. The flag stays set until reset.
- R7: When the read-side occupancy is zero, the underflow flag is set, with the same output and recentring as R6. The flag stays set until reset.
- R8: While bypass is high, each read clock loads the write-side input character into the output register unchanged. Framing characters are passed like any other character, and the error flags do not change.
- R9: The write pointer crosses into the read domain as a Gray code that changes by exactly one bit per write clock, through two read-clock flops.
- R10: The output is registered on the read clock. An input change between read edges does not appear at the output until the next read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_data | input | 8 | Decoded character, written every write clock |
| wr_stat | input | 3 | Status code of the character (3'b001 marks a special character) |
| rd_clk | input | 1 | Reference (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| bypass | input | 1 | High when the read side runs on the recovered clock |
| rd_data | output | 8 | Registered output character |
| rd_stat | output | 3 | Registered output status |
| ovf_err | output | 1 | Sticky overflow flag, read domain |
| unf_err | output | 1 | Sticky underflow flag, read domain |

## Verification
The embedded properties check the following on every cycle:
- the one-bit Gray step of the write pointer;
- that a held read pointer always shows a framing character;
- that a double-step of the read pointer only follows a framing head at high occupancy;
- the stickiness of both error flags;
- the bypass path from input to output register.

Other behaviours can only be shown by the bench's scenarios with mismatched clock frequencies:
- that ordering survives the clock crossing;
- that a fast writer produces net deletions and a slow writer net insertions;
- that data starved of framing characters ends in the correct error flag.

// File: rtl/eb_pkg.sv
package eb_pkg;

    // Default geometry and thresholds
    localparam int EB_DEPTH  = 10;
    localparam int EB_NOM    = 5;
    localparam int EB_DEL_TH = 5;
    localparam int EB_INS_TH = 2;
    localparam int EB_OVF_TH = 8;

    typedef struct packed {
        logic [2:0] stat;
        logic [7:0] data;
    } rx_char_t;

    localparam logic [7:0] COMMA_DATA   = 8'hBC;
    localparam logic [2:0] SPECIAL_STAT = 3'b001;
    localparam rx_char_t   COMMA_CHAR   = '{stat: SPECIAL_STAT, data: COMMA_DATA};

    typedef enum logic [2:0] {
        RD_PASS,
        RD_DROP,
        RD_HOLD,
        RD_OVF,
        RD_UNF,
        RD_BYP
    } rd_act_e;

    function automatic logic is_comma(rx_char_t c);
        return (c.stat == SPECIAL_STAT) && (c.data == COMMA_DATA);
    endfunction

    function automatic int unsigned mod_add(int unsigned a, int unsigned b, int unsigned m);
        int unsigned s;
        s = a + b;
        if (s >= m) s = s - m;
        return s;
    endfunction

    function automatic int unsigned mod_sub(int unsigned a, int unsigned b, int unsigned m);
        return (a >= b) ? (a - b) : (a + m - b);
    endfunction

    function automatic int unsigned slot_of(int unsigned p, int unsigned depth);
        return (p >= depth) ? (p - depth) : p;
    endfunction

    function automatic int unsigned bin2gray(int unsigned b);
        return b ^ (b >> 1);
    endfunction

    function automatic int unsigned gray2bin(int unsigned g);
        int unsigned r;
        r = g;
        for (int s = 1; s < 32; s = s * 2) r = r ^ (r >> s);
        return r;
    endfunction

endpackage

// File: rtl/eb_sync.sv
module eb_sync #(
    parameter int           W    = 4,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= INIT;
            q      <= INIT;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/eb_wr_side.sv
module eb_wr_side
    import eb_pkg::*;
#(
    parameter  int DEPTH = EB_DEPTH,
    parameter  int NOM   = EB_NOM,
    localparam int M     = 2 * DEPTH,
    localparam int PW    = $clog2(M),
    localparam int AW    = $clog2(DEPTH),
    localparam int OFS   = ((1 << PW) - M) / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  rx_char_t      din,
    output rx_char_t      store_q [DEPTH],
    output logic [PW-1:0] wgray_q
);
    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wptr_nx;
    logic [AW-1:0] waddr;

    always_comb begin
        wptr_nx = PW'(mod_add(32'(wptr_q), 1, M));
        waddr   = AW'(slot_of(32'(wptr_q), DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= PW'(NOM);
            wgray_q <= PW'(bin2gray(NOM + OFS));
            for (int i = 0; i < DEPTH; i++) store_q[i] <= COMMA_CHAR;
        end else begin
            store_q[waddr] <= din;
            wptr_q         <= wptr_nx;
            wgray_q        <= PW'(bin2gray(32'(wptr_nx) + OFS));
        end
    end

    // R9: one bit of the crossing code moves per write clock
    p_gray_step_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ($countones(wgray_q ^ $past(wgray_q)) == 1));
endmodule

// File: rtl/eb_rd_side.sv
module eb_rd_side
    import eb_pkg::*;
#(
    parameter  int DEPTH  = EB_DEPTH,
    parameter  int NOM    = EB_NOM,
    parameter  int DEL_TH = EB_DEL_TH,
    parameter  int INS_TH = EB_INS_TH,
    parameter  int OVF_TH = EB_OVF_TH,
    localparam int M      = 2 * DEPTH,
    localparam int PW     = $clog2(M),
    localparam int AW     = $clog2(DEPTH),
    localparam int OFS    = ((1 << PW) - M) / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bypass,
    input  rx_char_t      store [DEPTH],
    input  rx_char_t      thru,
    input  logic [PW-1:0] wgray_s,
    output rx_char_t      dout_q,
    output logic          ovf_q,
    output logic          unf_q
);
    logic [PW-1:0] rptr_q, rptr_nx, wbin, occ;
    logic [AW-1:0] ra, ra1;
    rx_char_t      head, nxt, dout_nx;
    rd_act_e       act;

    always_comb begin
        wbin = PW'(gray2bin(32'(wgray_s)) - OFS);
        occ  = PW'(mod_sub(32'(wbin), 32'(rptr_q), M));
        ra   = AW'(slot_of(32'(rptr_q), DEPTH));
        ra1  = AW'(slot_of(mod_add(32'(rptr_q), 1, M), DEPTH));
        head = store[ra];
        nxt  = store[ra1];

        if (bypass)                                act = RD_BYP;
        else if (occ == '0)                        act = RD_UNF;
        else if (32'(occ) >= OVF_TH)               act = RD_OVF;
        else if (is_comma(head) && 32'(occ) >= DEL_TH) act = RD_DROP;
        else if (is_comma(head) && 32'(occ) <= INS_TH) act = RD_HOLD;
        else                                       act = RD_PASS;

        unique case (act)
            RD_BYP: begin
                rptr_nx = rptr_q;
                dout_nx = thru;
            end
            RD_HOLD: begin
                rptr_nx = rptr_q;
                dout_nx = head;
            end
            RD_DROP: begin
                rptr_nx = PW'(mod_add(32'(rptr_q), 2, M));
                dout_nx = nxt;
            end
            RD_PASS: begin
                rptr_nx = PW'(mod_add(32'(rptr_q), 1, M));
                dout_nx = head;
            end
            default: begin
                rptr_nx = PW'(mod_sub(32'(wbin), NOM, M));
                dout_nx = COMMA_CHAR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q <= '0;
            dout_q <= COMMA_CHAR;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            rptr_q <= rptr_nx;
            dout_q <= dout_nx;
            ovf_q  <= ovf_q | (act == RD_OVF);
            unf_q  <= unf_q | (act == RD_UNF);
        end
    end

    // R6 / R7: error flags only clear through reset
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    p_unf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        unf_q |=> unf_q);

    // R4: a read pointer that stays put outside recentring repeats a framing character
    p_hold_comma_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(bypass) && rptr_q == $past(rptr_q)
         && $past(occ) != '0 && 32'($past(occ)) < OVF_TH)
        |-> is_comma(dout_q));

    // R3: a two-entry step only happens over a framing head at high occupancy
    p_drop_comma_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(bypass) && $past(occ) != '0 && 32'($past(occ)) < OVF_TH
         && rptr_q == PW'(mod_add(32'($past(rptr_q)), 2, M)))
        |-> ($past(is_comma(head)) && 32'($past(occ)) >= DEL_TH));

    // R8: in bypass the register takes the input seen at the read edge
    p_bypass_thru_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(bypass)) |-> (dout_q == $past(thru)));
endmodule

// File: rtl/elastic_rx_buf.sv
module elastic_rx_buf
    import eb_pkg::*;
#(
    parameter  int            DEPTH    = EB_DEPTH,
    parameter  int            NOM      = EB_NOM,
    parameter  int            DEL_TH   = EB_DEL_TH,
    parameter  int            INS_TH   = EB_INS_TH,
    parameter  int            OVF_TH   = EB_OVF_TH,
    localparam int            M        = 2 * DEPTH,
    localparam int            PW       = $clog2(M),
    localparam int            OFS      = ((1 << PW) - M) / 2,
    localparam logic [PW-1:0] GRAY_NOM = PW'(bin2gray(NOM + OFS))
) (
    input  logic       wr_clk,
    input  logic       wr_rst,
    input  logic [7:0] wr_data,
    input  logic [2:0] wr_stat,
    input  logic       rd_clk,
    input  logic       rd_rst,
    input  logic       bypass,
    output logic [7:0] rd_data,
    output logic [2:0] rd_stat,
    output logic       ovf_err,
    output logic       unf_err
);
    rx_char_t      in_char;
    rx_char_t      out_char;
    rx_char_t      store [DEPTH];
    logic [PW-1:0] wgray, wgray_s;

    assign in_char = '{stat: wr_stat, data: wr_data};

    eb_wr_side #(.DEPTH(DEPTH), .NOM(NOM)) u_wr (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .din     (in_char),
        .store_q (store),
        .wgray_q (wgray)
    );

    eb_sync #(.W(PW), .INIT(GRAY_NOM)) u_wsync (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wgray),
        .q   (wgray_s)
    );

    eb_rd_side #(
        .DEPTH(DEPTH), .NOM(NOM), .DEL_TH(DEL_TH),
        .INS_TH(INS_TH), .OVF_TH(OVF_TH)
    ) u_rd (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .bypass  (bypass),
        .store   (store),
        .thru    (in_char),
        .wgray_s (wgray_s),
        .dout_q  (out_char),
        .ovf_q   (ovf_err),
        .unf_q   (unf_err)
    );

    assign rd_data = out_char.data;
    assign rd_stat = out_char.stat;
endmodule

// File: tb/elastic_rx_buf_test.sv
module elastic_rx_buf_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst = 1'b1, rd_rst = 1'b1, bypass = 1'b0;
    logic [7:0] wr_data = 8'hBC;
    logic [2:0] wr_stat = 3'b001;
    logic [7:0] rd_data;
    logic [2:0] rd_stat;
    logic       ovf_err, unf_err;

    realtime wr_half = 5.0, rd_half = 5.0;
    int checks = 0, fails = 0;
    int cnt = 0;
    int in_frm = 0, out_frm = 0;
    bit mon_en = 1'b0;
    logic [10:0] exp_q [$];

    elastic_rx_buf uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_data(wr_data), .wr_stat(wr_stat),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .bypass(bypass),
        .rd_data(rd_data), .rd_stat(rd_stat), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    always #(wr_half) wr_clk = ~wr_clk;
    initial begin
        #1.3;
        forever #(rd_half) rd_clk = ~rd_clk;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: every 'every'-th character is framing; others are pushed to the scoreboard
    task automatic send(int n, int every, bit push);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            if (every != 0 && (i % every) == every - 1) begin
                wr_data = 8'hBC;
                wr_stat = 3'b001;
                in_frm++;
            end else begin
                cnt++;
                wr_data = cnt[7:0];
                wr_stat = {cnt[9], cnt[8], 1'b0};
                if (push) exp_q.push_back({wr_stat, wr_data});
            end
        end
        @(negedge wr_clk);
        wr_data = 8'hBC;
        wr_stat = 3'b001;
    endtask

    task automatic do_reset();
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        wr_data = 8'hBC;
        wr_stat = 3'b001;
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
        check(rd_data == 8'hBC && rd_stat == 3'b001, "R1", "output in reset",
              {rd_stat, rd_data}, 11'h1BC);
        check(!ovf_err && !unf_err, "R1", "flags in reset", {ovf_err, unf_err}, 0);
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge rd_clk) rd_rst = 1'b0;
        @(negedge rd_clk);
        check(rd_data == 8'hBC && rd_stat == 3'b001, "R1", "first read after reset",
              {rd_stat, rd_data}, 11'h1BC);
    endtask

    // Monitor: framing outputs may be inserted/dropped, others must match in order
    always @(negedge rd_clk) begin
        if (mon_en) begin
            if (rd_data == 8'hBC && rd_stat == 3'b001) begin
                out_frm++;
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected added character", {rd_stat, rd_data}, 11'h1BC);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                check({rd_stat, rd_data} == e, "R2", "order", {rd_stat, rd_data}, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge rd_clk);
        fails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int fin, fout;
        do_reset();
        mon_en = 1'b1;

        // Matched clocks (R2, R9)
        send(1000, 4, 1'b1);
        check(!ovf_err && !unf_err, "R2", "no error at matched rate", {ovf_err, unf_err}, 0);

        // Fast writer: net deletions (R3)
        wr_half = 4.75;
        fin = in_frm; fout = out_frm;
        send(2000, 4, 1'b1);
        check((out_frm - fout) < (in_frm - fin) - 40, "R3", "framing deleted",
              out_frm - fout, in_frm - fin);
        check(!ovf_err && !unf_err, "R3", "no error with fast writer", {ovf_err, unf_err}, 0);

        // Slow writer: net insertions (R4)
        wr_half = 5.25;
        fin = in_frm; fout = out_frm;
        send(2000, 4, 1'b1);
        check((out_frm - fout) > (in_frm - fin) + 40, "R4", "framing inserted",
              out_frm - fout, in_frm - fin);
        check(!ovf_err && !unf_err, "R4", "no error with slow writer", {ovf_err, unf_err}, 0);

        // Drain with framing only (R2, R9)
        wr_half = 5.0;
        send(40, 1, 1'b0);
        check(exp_q.size() == 0, "R2", "all characters delivered", exp_q.size(), 0);
        mon_en = 1'b0;
        exp_q.delete();

        // Overflow without framing characters (R6)
        wr_half = 4.0;
        send(300, 0, 1'b0);
        check(ovf_err == 1'b1, "R6", "overflow flag", ovf_err, 1);
        check(unf_err == 1'b0, "R6", "no underflow on overflow", unf_err, 0);
        wr_half = 5.0;
        send(50, 1, 1'b0);
        check(ovf_err == 1'b1, "R6", "overflow flag sticky", ovf_err, 1);

        // Underflow without framing characters (R7)
        do_reset();
        check(!ovf_err && !unf_err, "R7", "flags cleared by reset", {ovf_err, unf_err}, 0);
        wr_half = 7.0;
        send(200, 0, 1'b0);
        check(unf_err == 1'b1, "R7", "underflow flag", unf_err, 1);
        check(ovf_err == 1'b0, "R7", "no overflow on underflow", ovf_err, 0);
        wr_half = 5.0;
        send(50, 1, 1'b0);
        check(unf_err == 1'b1, "R7", "underflow flag sticky", unf_err, 1);

        // Bypass path (R8, R10)
        do_reset();
        bypass = 1'b1;
        @(negedge rd_clk);
        wr_data = 8'h5A; wr_stat = 3'b100;
        @(negedge rd_clk);
        check({rd_stat, rd_data} == {3'b100, 8'h5A}, "R8", "bypass pass", {rd_stat, rd_data}, {3'b100, 8'h5A});
        wr_data = 8'h33; wr_stat = 3'b010;
        #0.5;
        check({rd_stat, rd_data} == {3'b100, 8'h5A}, "R10", "registered between edges",
              {rd_stat, rd_data}, {3'b100, 8'h5A});
        @(negedge rd_clk);
        check({rd_stat, rd_data} == {3'b010, 8'h33}, "R10", "updates at read edge",
              {rd_stat, rd_data}, {3'b010, 8'h33});
        wr_data = 8'hBC; wr_stat = 3'b001;
        @(negedge rd_clk);
        wr_data = 8'h77; wr_stat = 3'b000;
        check({rd_stat, rd_data} == 11'h1BC, "R8", "framing passed in bypass",
              {rd_stat, rd_data}, 11'h1BC);
        for (int k = 0; k < 5; k++) begin
            @(negedge rd_clk);
            check({rd_stat, rd_data} == 11'h077, "R8", "held input repeated, none added",
                  {rd_stat, rd_data}, 11'h077);
        end
        check(!ovf_err && !unf_err, "R8", "no error flags in bypass", {ovf_err, unf_err}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule